// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver with Hardware Handshake

This block is a full-duplex asynchronous serial port with a byte-wide internal side. A character has a low start bit, eight data bits sent least significant bit first, an optional parity bit and one or two high stop bits. The line rate is not set by a clock divider. Software loads a rate key equal to the baud rate times 0.004096. A phase accumulator adds the key on every clock and wraps at 4096 times the clock frequency in MHz. This gives the same rate as a 12-bit accumulator stepped by a 1 MHz tick, but with finer phase resolution.

The transmitter takes one byte at a time through a valid/ready pair. When handshaking is enabled, it waits for the active-low clear-to-send input before it starts a character. A character that has already started always runs to its end.

The receiver oversamples the line with a second accumulator that wraps sixteen times as often. It detects a start bit from a falling edge and confirms it at mid-bit. It then samples each bit at its centre. Each received byte is written into a small receive queue together with its parity-error and framing-error flags. The active-low request-to-send output is raised when the queue is close to full.

Top module: `uart_fc_core`

## Requirements
- R1: After reset, `txd` is high, `tx_ready` is high, `rx_valid` is low and `rts_n` is low. `txd` is high at all times when no character is being sent.
- R2: One bit lasts 4096*CLK_MHZ/cfg_key clock cycles, so the baud rate is cfg_key/0.004096. Keys up to 256*CLK_MHZ are supported (12288, or 3 Mbaud, at 48 MHz). With CLK_MHZ=48, key 12288 gives 16 cycles per bit and key 6144 gives 32.
- R3: A transmitted character is sent in this order: a low start bit, data bits 0 through 7, the parity bit if enabled, then the stop bits, which are high.
- R4: `cfg_par` selects the parity mode: 2'b00 none, 2'b01 odd, 2'b10 even, and 2'b11 none. For odd parity, the data bits and the parity bit together hold an odd number of ones. For even parity, they hold an even number.
- R5: With `cfg_two_stop`=1, the transmitter sends two stop bit times. `tx_ready` returns high exactly (10 + parity + stop-extra) bit times after the start bit begins.
- R6: While `cfg_flow_en`=1 and `cts_n` is high, no new character starts. If `cts_n` rises during a character, that character still completes.
- R7: The receiver decodes characters in the configured format, data least significant bit first, and places each byte in the receive queue. Bytes leave the queue in arrival order, one byte per cycle in which `rx_ready` is high and `rx_valid` is high.
- R8: `rx_perr` is high for a byte whose received parity bit does not match the configured mode. It is low when parity is disabled.
- R9: `rx_ferr` is high for a byte whose first stop bit samples low. The data byte is still delivered.
- R10: With `cfg_flow_en`=1, `rts_n` is high when the receive queue has RTS_FREE_MIN (2) or fewer free entries, and low otherwise. With `cfg_flow_en`=0, `rts_n` is low.
- R11: When the queue (RX_DEPTH entries) is full, a newly received byte is discarded and the stored bytes are not changed.
- R12: A low pulse on `rxd` that is high again at the middle of the start bit is ignored. A start is recognised only after a high-to-low transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of CLK_MHZ MHz |
| rst | input | 1 | Synchronous active-high reset |
| cfg_key | input | KEY_W | Rate key, equal to baud times 0.004096 |
| cfg_par | input | 2 | Parity mode: 00 none, 01 odd, 10 even, 11 none |
| cfg_two_stop | input | 1 | Send two stop bits when 1 |
| cfg_flow_en | input | 1 | Enable the RTS/CTS handshake |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Transmitter idle; accepts a byte |
| txd | output | 1 | Serial output, idles high |
| cts_n | input | 1 | Clear to send, active low |
| rxd | input | 1 | Serial input, idles high |
| rx_valid | output | 1 | Receive queue holds a byte |
| rx_data | output | 8 | Oldest received byte |
| rx_perr | output | 1 | Parity error flag of that byte |
| rx_ferr | output | 1 | Framing error flag of that byte |
| rx_ready | input | 1 | Remove the oldest byte |
| rts_n | output | 1 | Request to send, active low |

## Verification
Transmit shifting and receive sampling share the configuration and can both be active in the same cycles. A full-duplex scenario starts a parity-framed transmission and, at the same time, drives a parity-framed character into `rxd`. The bench judges the result in two ways: a bit-exact capture of `txd` taken at mid-bit, and the flags and data of the byte popped from the queue. A second pair of functions that can coincide is a receive write and the `rts_n` threshold update. The queue is filled byte by byte, and `rts_n` is checked after each write around the two-free-entries boundary and again at overflow.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;
  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ODD  = 2'b01,
    PAR_EVEN = 2'b10,
    PAR_RSVD = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_word_t;

  function automatic logic parity_of(input logic [7:0] d, input logic odd);
    return odd ? ~^d : ^d;
  endfunction
endpackage

// File: rtl/uart_phase_acc.sv
module uart_phase_acc #(
  parameter int MOD   = 4096,
  parameter int KEY_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [KEY_W-1:0] key,
  output logic             stb
);
  localparam int ACC_W = $clog2(MOD);
  localparam int SW    = ((ACC_W > KEY_W) ? ACC_W : KEY_W) + 1;

  logic [SW-1:0] acc, sum;

  always_comb begin
    sum = acc + SW'(key);
    stb = (sum >= SW'(MOD));
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  acc <= '0;
    else if (stb)    acc <= sum - SW'(MOD);
    else             acc <= sum;
  end

  // R2: phase stays inside one wrap period
  a_r2_acc_in_range: assert property (@(posedge clk) disable iff (rst)
    acc < SW'(MOD));
endmodule

// File: rtl/uart_tx_eng.sv
module uart_tx_eng import uart_fc_pkg::*; #(
  parameter int KEY_W = 14,
  parameter int MOD   = 196608
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [KEY_W-1:0] key,
  input  logic [1:0]       par_mode,
  input  logic             two_stop,
  input  logic             flow_en,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             txd,
  input  logic             cts_n
);
  logic        cts_m, cts_s;
  logic        busy, start, stb, par_en, pbit;
  logic [10:0] sh;
  logic [3:0]  left;

  always_ff @(posedge clk) begin
    if (rst) begin
      cts_m <= 1'b1;
      cts_s <= 1'b1;
    end else begin
      cts_m <= cts_n;
      cts_s <= cts_m;
    end
  end

  always_comb begin
    par_en = (par_mode == PAR_ODD) || (par_mode == PAR_EVEN);
    pbit   = parity_of(tx_data, par_mode == PAR_ODD);
    start  = tx_valid && !busy && !(flow_en && cts_s);
  end

  uart_phase_acc #(.MOD(MOD), .KEY_W(KEY_W)) u_rate (
    .clk(clk), .rst(rst), .clr(start), .key(key), .stb(stb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      txd  <= 1'b1;
      sh   <= '1;
      left <= '0;
    end else if (start) begin
      busy <= 1'b1;
      txd  <= 1'b0;
      sh   <= par_en ? {2'b11, pbit, tx_data} : {3'b111, tx_data};
      left <= 4'd9 + {3'b000, par_en} + {3'b000, two_stop};
    end else if (busy && stb) begin
      if (left == 4'd0) begin
        busy <= 1'b0;
      end else begin
        txd  <= sh[0];
        sh   <= {1'b1, sh[10:1]};
        left <= left - 4'd1;
      end
    end
  end

  assign tx_ready = ~busy;

  a_r1_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  a_r3_start_bit_low: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);
  a_r6_hold_while_blocked: assert property (@(posedge clk) disable iff (rst)
    (!busy && flow_en && cts_s) |=> !busy);
endmodule

// File: rtl/uart_rx_eng.sv
module uart_rx_eng import uart_fc_pkg::*; #(
  parameter int KEY_W = 14,
  parameter int MOD16 = 12288
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [KEY_W-1:0] key,
  input  logic [1:0]       par_mode,
  input  logic             rxd,
  output logic             push,
  output rx_word_t         word
);
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_state_e;

  rx_state_e   state;
  logic        rx_m, rx_s, rx_d, stb, par_en, perr;
  logic [3:0]  os;
  logic [2:0]  idx;
  logic [7:0]  dat;

  assign par_en = (par_mode == PAR_ODD) || (par_mode == PAR_EVEN);

  uart_phase_acc #(.MOD(MOD16), .KEY_W(KEY_W)) u_os (
    .clk(clk), .rst(rst), .clr(1'b0), .key(key), .stb(stb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_m <= 1'b1; rx_s <= 1'b1; rx_d <= 1'b1;
    end else begin
      rx_m <= rxd; rx_s <= rx_m; rx_d <= rx_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      push  <= 1'b0;
      os    <= '0;
      idx   <= '0;
      dat   <= '0;
      perr  <= 1'b0;
      word  <= '0;
    end else begin
      push <= 1'b0;
      case (state)
        RX_IDLE: if (rx_d && !rx_s) begin
          state <= RX_START;
          os    <= '0;
        end
        RX_START: if (stb) begin
          if (os == 4'd7) begin
            state <= rx_s ? RX_IDLE : RX_DATA;
            os    <= '0;
            idx   <= '0;
            perr  <= 1'b0;
          end else os <= os + 4'd1;
        end
        RX_DATA: if (stb) begin
          if (os == 4'd15) begin
            os  <= '0;
            dat <= {rx_s, dat[7:1]};
            idx <= idx + 3'd1;
            if (idx == 3'd7) state <= par_en ? RX_PAR : RX_STOP;
          end else os <= os + 4'd1;
        end
        RX_PAR: if (stb) begin
          if (os == 4'd15) begin
            os    <= '0;
            perr  <= (rx_s != parity_of(dat, par_mode == PAR_ODD));
            state <= RX_STOP;
          end else os <= os + 4'd1;
        end
        RX_STOP: if (stb) begin
          if (os == 4'd15) begin
            push  <= 1'b1;
            word  <= '{ferr: !rx_s, perr: perr, data: dat};
            state <= RX_IDLE;
          end else os <= os + 4'd1;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  a_r9_push_from_stop: assert property (@(posedge clk) disable iff (rst)
    push |-> $past(state) == RX_STOP);
  a_r12_start_needs_fall: assert property (@(posedge clk) disable iff (rst)
    (state == RX_IDLE && !(rx_d && !rx_s)) |=> state == RX_IDLE);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 10
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [W-1:0]               wdata,
  input  logic                       pop,
  output logic                       rvalid,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          wr, rd;

  assign wr     = push && (count != (AW+1)'(DEPTH));
  assign rd     = pop && (count != '0);
  assign rvalid = (count != '0);
  assign rdata  = mem[rp];

  always_ff @(posedge clk) begin
    if (wr) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (wr) wp <= wp + AW'(1);
      if (rd) rp <= rp + AW'(1);
      count <= count + (AW+1)'(wr) - (AW+1)'(rd);
    end
  end

  a_r11_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= (AW+1)'(DEPTH));
  a_r11_full_drop: assert property (@(posedge clk) disable iff (rst)
    (count == (AW+1)'(DEPTH) && push && !pop) |=> count == (AW+1)'(DEPTH));
endmodule

// File: rtl/uart_fc_core.sv
module uart_fc_core import uart_fc_pkg::*; #(
  parameter int CLK_MHZ      = 48,
  parameter int KEY_W        = 14,
  parameter int RX_DEPTH     = 8,
  parameter int RTS_FREE_MIN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [KEY_W-1:0] cfg_key,
  input  logic [1:0]       cfg_par,
  input  logic             cfg_two_stop,
  input  logic             cfg_flow_en,
  input  logic             tx_valid,
  input  logic [7:0]       tx_data,
  output logic             tx_ready,
  output logic             txd,
  input  logic             cts_n,
  input  logic             rxd,
  output logic             rx_valid,
  output logic [7:0]       rx_data,
  output logic             rx_perr,
  output logic             rx_ferr,
  input  logic             rx_ready,
  output logic             rts_n
);
  localparam int TX_MOD = 4096 * CLK_MHZ;
  localparam int RX_MOD = 256 * CLK_MHZ;
  localparam int CW     = $clog2(RX_DEPTH) + 1;

  rx_word_t        in_word, out_word;
  logic            in_push;
  logic [CW-1:0]   fill, free_cnt;

  uart_tx_eng #(.KEY_W(KEY_W), .MOD(TX_MOD)) u_tx (
    .clk(clk), .rst(rst), .key(cfg_key), .par_mode(cfg_par),
    .two_stop(cfg_two_stop), .flow_en(cfg_flow_en), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd), .cts_n(cts_n)
  );

  uart_rx_eng #(.KEY_W(KEY_W), .MOD16(RX_MOD)) u_rx (
    .clk(clk), .rst(rst), .key(cfg_key), .par_mode(cfg_par), .rxd(rxd),
    .push(in_push), .word(in_word)
  );

  uart_rx_fifo #(.DEPTH(RX_DEPTH), .W($bits(rx_word_t))) u_q (
    .clk(clk), .rst(rst), .push(in_push), .wdata(in_word), .pop(rx_ready),
    .rvalid(rx_valid), .rdata(out_word), .count(fill)
  );

  assign rx_data  = out_word.data;
  assign rx_perr  = out_word.perr;
  assign rx_ferr  = out_word.ferr;
  assign free_cnt = CW'(RX_DEPTH) - fill;

  always_ff @(posedge clk) begin
    if (rst) rts_n <= 1'b0;
    else     rts_n <= cfg_flow_en && (free_cnt <= CW'(RTS_FREE_MIN));
  end

  a_r10_rts_needs_flow: assert property (@(posedge clk) disable iff (rst)
    rts_n |-> $past(cfg_flow_en));
endmodule

// File: tb/uart_fc_core_tb_top.sv
module uart_fc_core_tb_top;
  logic        clk = 1'b0, rst = 1'b1;
  logic [13:0] cfg_key = 14'd12288;
  logic [1:0]  cfg_par = 2'b00;
  logic        cfg_two_stop = 1'b0, cfg_flow_en = 1'b0;
  logic        tx_valid = 1'b0, cts_n = 1'b0, rxd = 1'b1, rx_ready = 1'b0;
  logic [7:0]  tx_data = 8'h00;
  logic        tx_ready, txd, rx_valid, rx_perr, rx_ferr, rts_n;
  logic [7:0]  rx_data;
  int          total = 0, fails = 0;

  always #5 clk = ~clk;

  uart_fc_core dut_i (
    .clk(clk), .rst(rst), .cfg_key(cfg_key), .cfg_par(cfg_par),
    .cfg_two_stop(cfg_two_stop), .cfg_flow_en(cfg_flow_en),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready), .txd(txd),
    .cts_n(cts_n), .rxd(rxd), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ready(rx_ready), .rts_n(rts_n)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic par_exp(input logic [7:0] d, input logic [1:0] pm);
    return (pm == 2'b01) ? ((($countones(d) % 2) == 0) ? 1'b1 : 1'b0)
                         : ((($countones(d) % 2) == 1) ? 1'b1 : 1'b0);
  endfunction

  function automatic int frame_len(input logic [1:0] pm, input bit two);
    return 10 + ((pm == 2'b01 || pm == 2'b10) ? 1 : 0) + (two ? 1 : 0);
  endfunction

  function automatic logic [11:0] frame_bits(input logic [7:0] d, input logic [1:0] pm);
    logic [11:0] f;
    f = '1; f[0] = 1'b0; f[8:1] = d;
    if (pm == 2'b01 || pm == 2'b10) f[9] = par_exp(d, pm);
    return f;
  endfunction

  task automatic offer_tx(input logic [7:0] d);
    @(posedge clk); #1 tx_valid = 1'b1; tx_data = d;
    @(posedge clk); #1 tx_valid = 1'b0;
  endtask

  task automatic capture_tx(input int B, input logic [7:0] d, input bit aligned,
                            input string req);
    logic [11:0] exp, got, mask;
    int n, cnt;
    exp = frame_bits(d, cfg_par);
    n = frame_len(cfg_par, cfg_two_stop);
    mask = 12'((1 << n) - 1);
    got = '1; cnt = 0;
    if (!aligned) begin
      @(negedge clk);
      while (txd) @(negedge clk);
    end
    while (!tx_ready && cnt < 4000) begin
      if ((cnt % B) == (B / 2) && (cnt / B) < 12) got[cnt / B] = txd;
      cnt++;
      @(negedge clk);
    end
    chk(((got ^ exp) & mask) == 0, req, "frame bits", got & mask, exp & mask);
    chk(cnt == n * B, req, "frame length cycles", cnt, n * B);
    chk(txd == 1'b1, "R1", "line idle after frame", txd, 1);
  endtask

  task automatic send_rx(input logic [7:0] d, input bit flip, input logic stopv, input int B);
    logic [11:0] f;
    int n;
    f = frame_bits(d, cfg_par);
    n = (cfg_par == 2'b01 || cfg_par == 2'b10) ? 10 : 9;
    if (n == 10) f[9] = f[9] ^ flip;
    f[n] = stopv;
    n++;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 rxd = f[i];
      repeat (B - 1) @(posedge clk);
    end
    @(posedge clk); #1 rxd = 1'b1;
    repeat (B) @(posedge clk);
  endtask

  task automatic pop_chk(input logic [7:0] d, input logic pe, input logic fe, input string req);
    @(negedge clk);
    chk(rx_valid == 1'b1, req, "rx_valid", rx_valid, 1);
    chk(rx_data == d, req, "rx_data", rx_data, d);
    chk(rx_perr == pe, req, "rx_perr", rx_perr, pe);
    chk(rx_ferr == fe, req, "rx_ferr", rx_ferr, fe);
    @(posedge clk); #1 rx_ready = 1'b1;
    @(posedge clk); #1 rx_ready = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(txd == 1'b1, "R1", "txd after reset", txd, 1);
    chk(tx_ready == 1'b1, "R1", "tx_ready after reset", tx_ready, 1);
    chk(rx_valid == 1'b0, "R1", "rx_valid after reset", rx_valid, 0);
    chk(rts_n == 1'b0, "R1", "rts_n after reset", rts_n, 0);
  endtask

  task automatic t_tx_formats;
    cfg_key = 14'd12288; cfg_par = 2'b00; cfg_two_stop = 1'b0;
    offer_tx(8'h01); capture_tx(16, 8'h01, 1'b0, "R2 R3 16-cycle bits");
    cfg_key = 14'd6144;
    offer_tx(8'hA5); capture_tx(32, 8'hA5, 1'b0, "R2 R3 32-cycle bits");
    cfg_key = 14'd12288; cfg_par = 2'b01;
    offer_tx(8'h03); capture_tx(16, 8'h03, 1'b0, "R4 odd parity");
    cfg_par = 2'b10;
    offer_tx(8'h07); capture_tx(16, 8'h07, 1'b0, "R4 even parity");
    cfg_par = 2'b11;
    offer_tx(8'h07); capture_tx(16, 8'h07, 1'b0, "R4 code 11 no parity");
    cfg_par = 2'b10; cfg_two_stop = 1'b1;
    offer_tx(8'h80); capture_tx(16, 8'h80, 1'b0, "R5 two stop bits");
    cfg_par = 2'b00; cfg_two_stop = 1'b0;
  endtask

  task automatic t_tx_flow;
    cfg_flow_en = 1'b1; cts_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 tx_valid = 1'b1; tx_data = 8'h5C;
    repeat (50) @(negedge clk);
    chk(txd == 1'b1, "R6", "txd held while cts_n high", txd, 1);
    chk(tx_ready == 1'b1, "R6", "no start while cts_n high", tx_ready, 1);
    cts_n = 1'b0;
    @(negedge clk);
    while (txd) @(negedge clk);
    tx_valid = 1'b0; cts_n = 1'b1;
    capture_tx(16, 8'h5C, 1'b1, "R6 frame completes after cts_n rise");
    cts_n = 1'b0; cfg_flow_en = 1'b0;
  endtask

  task automatic t_rx_basic;
    cfg_par = 2'b00;
    send_rx(8'hA5, 1'b0, 1'b1, 16); pop_chk(8'hA5, 1'b0, 1'b0, "R7 plain byte");
    cfg_key = 14'd6144;
    send_rx(8'h3E, 1'b0, 1'b1, 32); pop_chk(8'h3E, 1'b0, 1'b0, "R7 R2 slower key");
    cfg_key = 14'd12288;
  endtask

  task automatic t_rx_errors;
    cfg_par = 2'b01;
    send_rx(8'h5A, 1'b0, 1'b1, 16); pop_chk(8'h5A, 1'b0, 1'b0, "R8 odd parity good");
    send_rx(8'h5A, 1'b1, 1'b1, 16); pop_chk(8'h5A, 1'b1, 1'b0, "R8 odd parity bad");
    cfg_par = 2'b10;
    send_rx(8'h71, 1'b1, 1'b1, 16); pop_chk(8'h71, 1'b1, 1'b0, "R8 even parity bad");
    cfg_par = 2'b00;
    send_rx(8'hC9, 1'b0, 1'b0, 16); pop_chk(8'hC9, 1'b0, 1'b1, "R9 stop low");
    repeat (40) @(negedge clk);
    chk(rx_valid == 1'b0, "R9", "no extra byte after low stop", rx_valid, 0);
  endtask

  task automatic t_rx_glitch;
    @(posedge clk); #1 rxd = 1'b0;
    repeat (3) @(posedge clk);
    #1 rxd = 1'b1;
    repeat (320) @(negedge clk);
    chk(rx_valid == 1'b0, "R12", "short low pulse ignored", rx_valid, 0);
    send_rx(8'h3C, 1'b0, 1'b1, 16); pop_chk(8'h3C, 1'b0, 1'b0, "R12 receiver still works");
  endtask

  task automatic t_rts_fill;
    cfg_flow_en = 1'b1; cfg_par = 2'b00;
    for (int i = 0; i < 5; i++) send_rx(8'h10 + 8'(i), 1'b0, 1'b1, 16);
    @(negedge clk);
    chk(rts_n == 1'b0, "R10", "rts_n with 3 free", rts_n, 0);
    send_rx(8'h15, 1'b0, 1'b1, 16);
    @(negedge clk);
    chk(rts_n == 1'b1, "R10", "rts_n with 2 free", rts_n, 1);
    cfg_flow_en = 1'b0;
    repeat (2) @(negedge clk);
    chk(rts_n == 1'b0, "R10", "rts_n with flow disabled", rts_n, 0);
    cfg_flow_en = 1'b1;
    for (int i = 6; i < 9; i++) send_rx(8'h10 + 8'(i), 1'b0, 1'b1, 16);
    @(negedge clk);
    chk(rts_n == 1'b1, "R10", "rts_n when full", rts_n, 1);
    for (int i = 0; i < 8; i++) pop_chk(8'h10 + 8'(i), 1'b0, 1'b0, "R11 order after fill");
    repeat (2) @(negedge clk);
    chk(rx_valid == 1'b0, "R11", "overflow byte discarded", rx_valid, 0);
    chk(rts_n == 1'b0, "R10", "rts_n after drain", rts_n, 0);
    cfg_flow_en = 1'b0;
  endtask

  task automatic t_duplex;
    cfg_par = 2'b10;
    fork
      begin offer_tx(8'hC3); capture_tx(16, 8'hC3, 1'b0, "R3 R4 duplex transmit"); end
      send_rx(8'h96, 1'b0, 1'b1, 16);
    join
    pop_chk(8'h96, 1'b0, 1'b0, "R7 R8 duplex receive");
    cfg_par = 2'b00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_tx_formats();
    t_tx_flow();
    t_rx_basic();
    t_rx_errors();
    t_rx_glitch();
    t_rts_fill();
    t_duplex();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule